// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

An eight-line priority interrupt controller reached through a small register bus: chip select, one address bit choosing the command port (`addr_i`=0) or the data port (`addr_i`=1), read and write strobes, and byte-wide data. Request lines feed a request register. Unmasked requests are arbitrated against the in-service register under a priority order whose lowest-priority line is programmable, and the result drives `irq_o`. A one-cycle acknowledge pulse moves the winner into service and returns a vector.

Software configures the block with a short initialization word sequence. It then controls the block with end-of-interrupt, priority-rotation and read-select commands. The cascade configuration word is held and presented on `casc_o` for the surrounding logic to use; the block has no cascade bus of its own.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, the mask register reads 0xFF on the data port, the command port reads the request register, and line 7 has the lowest priority.
- R2: A command write with bit 4 set starts initialization. Its bit 0 asks for a mode word and its bit 3 selects level triggering. The next data writes load, in order, the vector base, the cascade word (`casc_o`) and, when bit 0 was set, the mode word. After that, data writes load the mask and data reads return it.
- R3: Command reads return the request register until a read-select command arrives (bits 4:3 = 01, bit 1 = 1). Bit 0 of that command then chooses the in-service register (1) or the request register (0).
- R4: `irq_o` is 1 exactly when some unmasked pending line has strictly higher current priority than every in-service line.
- R5: On an acknowledge taken while `irq_o` is 1, `vec_o` shows base + winning line from the next cycle, and the winning line's in-service bit is set.
- R6: In edge mode (first-word bit 3 = 0), a request bit is set on a rising input edge, is cleared by acknowledge, and stays clear while the input is held high. In level mode the request bit follows the input.
- R7: Command 0x20 (bits 7:5 = 001) clears the highest-priority in-service bit.
- R8: With mode-word bit 1 set (auto end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R9: Command bits 7:5 = 110 make the line in bits 2:0 the lowest priority. After naming line 2, the service order is 3,4,5,6,7,0,1,2.
- R10: An acknowledge taken while `irq_o` is 0 returns base + 7 and changes no in-service bit.
- R11: Bits 7:5 = 011 clear the in-service bit of the line in bits 2:0. Bits 7:5 = 101 clear the highest-priority in-service bit and make that line the lowest priority.
- R12: A masked line never asserts `irq_o`, but its request bit remains visible in the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| addr_i | input | 1 | 0 = command port, 1 = data port |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, zero when not reading |
| req_i | input | 8 | Interrupt request lines |
| ack_i | input | 1 | Acknowledge pulse |
| irq_o | output | 1 | Interrupt output |
| vec_o | output | 8 | Vector of the last acknowledge |
| casc_o | output | 8 | Stored cascade configuration word |

## Verification
Every lowest-priority setting is crossed with every non-zero request pattern in level mode. This separates a wrong rotation base from a wrong scan direction, and an off-by-one in the vector adder from a wrong winner. Directed patterns then stack in-service lines: a lower-priority request arriving under a higher in-service line must stay silent, while a higher one must break through. Edge-held inputs, a withdrawn request, a masked line, auto end-of-interrupt and rotate-on-EOI each separate one state-update path from its neighbours.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {ST_READY, ST_BASE, ST_CASC, ST_MODE} init_st_e;
  localparam logic [2:0] OP_NS_EOI  = 3'b001;
  localparam logic [2:0] OP_SP_EOI  = 3'b011;
  localparam logic [2:0] OP_ROT_NS  = 3'b101;
  localparam logic [2:0] OP_SET_LOW = 3'b110;
  localparam logic [2:0] OP_ROT_SP  = 3'b111;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] req_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      irr_o <= '0;
    end else begin
      req_q <= req_i;
      if (level_i) irr_o <= req_i;
      else         irr_o <= (irr_o | (req_i & ~req_q)) & req_i & ~clr_i;
    end
  end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isr_i,
  input  logic [LW-1:0] low_i,
  output logic          irq_o,
  output logic [LW-1:0] win_o,
  output logic          top_vld_o,
  output logic [LW-1:0] top_o
);
  logic          p_fnd, i_fnd;
  logic [LW-1:0] p_rank, i_rank;
  logic [LW-1:0] line;

  // rank 0 is the line just above the lowest-priority one
  always_comb begin
    p_fnd = 1'b0; i_fnd = 1'b0;
    p_rank = '0;  i_rank = '0;
    win_o = '0;   top_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      line = LW'(int'(low_i) + 1 + k);
      if (pend_i[line]) begin p_fnd = 1'b1; p_rank = LW'(k); win_o = line; end
      if (isr_i[line])  begin i_fnd = 1'b1; i_rank = LW'(k); top_o = line; end
    end
    top_vld_o = i_fnd;
    irq_o = p_fnd && (!i_fnd || p_rank < i_rank);
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] data_i,
  input  logic          ack_i,
  input  logic          irq_v_i,
  input  logic [LW-1:0] win_i,
  input  logic          top_vld_i,
  input  logic [LW-1:0] top_i,
  output logic          ready_o,
  output logic          level_o,
  output logic          aeoi_o,
  output logic          rsel_o,
  output logic [LW-1:0] low_o,
  output logic [N-1:0]  imr_o,
  output logic [N-1:0]  isr_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] casc_o,
  output logic [DW-1:0] vec_o
);
  init_st_e      st_q;
  logic          need4_q;
  logic [LW-1:0] line;
  assign line    = data_i[LW-1:0];
  assign ready_o = (st_q == ST_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_READY; need4_q <= 1'b0; level_o <= 1'b0; aeoi_o <= 1'b0;
      rsel_o <= 1'b0; low_o <= LW'(N - 1); imr_o <= '1; isr_o <= '0;
      base_o <= '0; casc_o <= '0; vec_o <= '0;
    end else begin
      if (ack_i) begin
        if (irq_v_i) begin
          vec_o <= base_o + DW'(win_i);
          if (!aeoi_o) isr_o[win_i] <= 1'b1;
        end else begin
          vec_o <= base_o + DW'(N - 1);
        end
      end
      if (cmd_we_i) begin
        if (data_i[4]) begin
          st_q <= ST_BASE; need4_q <= data_i[0]; level_o <= data_i[3];
          aeoi_o <= 1'b0; rsel_o <= 1'b0; low_o <= LW'(N - 1); isr_o <= '0;
        end else if (data_i[3]) begin
          if (data_i[1]) rsel_o <= data_i[0];
        end else begin
          case (data_i[7:5])
            OP_NS_EOI:  if (top_vld_i) isr_o[top_i] <= 1'b0;
            OP_SP_EOI:  isr_o[line] <= 1'b0;
            OP_ROT_NS:  if (top_vld_i) begin isr_o[top_i] <= 1'b0; low_o <= top_i; end
            OP_SET_LOW: low_o <= line;
            OP_ROT_SP:  begin isr_o[line] <= 1'b0; low_o <= line; end
            default: ;
          endcase
        end
      end else if (dat_we_i) begin
        case (st_q)
          ST_BASE:  begin base_o <= data_i; st_q <= ST_CASC; end
          ST_CASC:  begin casc_o <= data_i; st_q <= need4_q ? ST_MODE : ST_READY; end
          ST_MODE:  begin aeoi_o <= data_i[1]; st_q <= ST_READY; end
          default:  imr_o <= data_i[N-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  input  logic [N-1:0]  req_i,
  input  logic          ack_i,
  output logic          irq_o,
  output logic [DW-1:0] vec_o,
  output logic [DW-1:0] casc_o
);
  localparam int LW = $clog2(N);

  logic [N-1:0]  irr_w, isr_w, imr_w, clr_w;
  logic [LW-1:0] low_w, win_w, top_w;
  logic [DW-1:0] base_w;
  logic          level_w, aeoi_w, rsel_w, ready_w, arb_irq_w, top_vld_w, cmd_we_w;

  assign cmd_we_w = cs_i & wr_i & ~addr_i;
  assign irq_o    = arb_irq_w & ready_w;
  assign clr_w    = (ack_i && irq_o) ? (N'(1) << win_w) : '0;

  pic_req_latch #(.N(N)) u_req (
    .clk_i, .rst_ni, .level_i(level_w), .req_i, .clr_i(clr_w), .irr_o(irr_w)
  );

  pic_prio_resolve #(.N(N), .LW(LW)) u_prio (
    .pend_i(irr_w & ~imr_w), .isr_i(isr_w), .low_i(low_w),
    .irq_o(arb_irq_w), .win_o(win_w), .top_vld_o(top_vld_w), .top_o(top_w)
  );

  pic_regs #(.N(N), .DW(DW), .LW(LW)) u_regs (
    .clk_i, .rst_ni, .cmd_we_i(cmd_we_w), .dat_we_i(cs_i & wr_i & addr_i),
    .data_i, .ack_i, .irq_v_i(irq_o), .win_i(win_w), .top_vld_i(top_vld_w),
    .top_i(top_w), .ready_o(ready_w), .level_o(level_w), .aeoi_o(aeoi_w),
    .rsel_o(rsel_w), .low_o(low_w), .imr_o(imr_w), .isr_o(isr_w),
    .base_o(base_w), .casc_o, .vec_o
  );

  always_comb begin
    data_o = '0;
    if (cs_i && rd_i) begin
      if (addr_i)      data_o = DW'(imr_w);
      else if (rsel_w) data_o = DW'(isr_w);
      else             data_o = DW'(irr_w);
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic          irq_o,
  input logic          cmd_we_w,
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] vec_o,
  input logic [DW-1:0] base_w,
  input logic [N-1:0]  isr_w,
  input logic [N-1:0]  irr_w,
  input logic [N-1:0]  imr_w,
  input logic          aeoi_w
);
  p_irq_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irr_w & ~imr_w) != '0);
  p_ack_sets_isr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !aeoi_w && !cmd_we_w) |=> $countones(isr_w) == $past($countones(isr_w)) + 1);
  p_ns_eoi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_w && data_i == 8'h20 && isr_w != '0 && !ack_i) |=> $countones(isr_w) == $past($countones(isr_w)) - 1);
  p_aeoi_keeps_isr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi_w && !cmd_we_w) |=> $stable(isr_w));
  p_spurious_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !cmd_we_w) |=> (vec_o == $past(base_w) + DW'(N - 1)) && $stable(isr_w));
endmodule

bind prio_irq_ctrl pic_chk #(.N(N), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .ack_i, .irq_o, .cmd_we_w, .data_i, .vec_o,
  .base_w, .isr_w, .irr_w, .imr_w, .aeoi_w
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs = 0, addr = 0, rd = 0, wr = 0, ack = 0;
  logic [7:0] din = 0, req = 0;
  logic [7:0] dout, vec, casc;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni, .cs_i(cs), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .data_i(din), .data_o(dout), .req_i(req), .ack_i(ack), .irq_o(irq),
    .vec_o(vec), .casc_o(casc)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    @(negedge clk); cs = 1; addr = a; wr = 1; din = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; addr = a; rd = 1; #1 d = dout; cs = 0; rd = 0;
  endtask

  task automatic rd_isr(output logic [7:0] d);
    wr_reg(0, 8'h0B); rd_reg(0, d); wr_reg(0, 8'h0A);
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic set_req(logic [7:0] r);
    @(negedge clk); req = r;
    @(negedge clk);
  endtask

  task automatic init(logic lvl, logic [7:0] base, logic aeoi);
    wr_reg(0, 8'h11 | (lvl ? 8'h08 : 8'h00));
    wr_reg(1, base);
    wr_reg(1, 8'h04);
    wr_reg(1, aeoi ? 8'h03 : 8'h01);
    wr_reg(1, 8'h00);
  endtask

  function automatic int winner(int low, logic [7:0] p);
    for (int k = 0; k < 8; k++) if (p[(low + 1 + k) % 8]) return (low + 1 + k) % 8;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int w;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd_reg(1, d); chk("R1 mask", d, 8'hFF);
    rd_reg(0, d); chk("R1 irr", d, 8'h00);
    // R2 init sequence, mask access, cascade word
    init(1, 8'h20, 0);
    chk("R2 casc", casc, 8'h04);
    rd_reg(1, d); chk("R2 mask0", d, 8'h00);
    wr_reg(1, 8'h5A); rd_reg(1, d); chk("R2 mask", d, 8'h5A);
    wr_reg(1, 8'h00);
    // R9 R4 R5 R3 R7 sweep: every lowest line x every request pattern
    for (int low = 0; low < 8; low++) begin
      wr_reg(0, 8'hC0 | 8'(low));
      for (int p = 1; p < 256; p++) begin
        w = winner(low, 8'(p));
        set_req(8'(p));
        rd_reg(0, d); chk("R3 irr", d, 8'(p));
        chk("R4 irq", {7'b0, irq}, 8'h01);
        pulse_ack;
        chk("R5 R9 vec", vec, 8'h20 + 8'(w));
        rd_isr(d); chk("R5 isr", d, 8'h01 << w);
        chk("R4 nested", {7'b0, irq}, 8'h00);
        wr_reg(0, 8'h20);
        rd_isr(d); chk("R7 eoi", d, 8'h00);
        set_req(8'h00);
      end
    end
    // R4 nesting with line 7 lowest
    wr_reg(0, 8'hC7);
    set_req(8'h10); pulse_ack;
    set_req(8'h30); chk("R4 lower blocked", {7'b0, irq}, 8'h00);
    set_req(8'h38); chk("R4 higher passes", {7'b0, irq}, 8'h01);
    pulse_ack; chk("R5 vec3", vec, 8'h23);
    rd_isr(d); chk("R5 isr2", d, 8'h18);
    wr_reg(0, 8'h20); rd_isr(d); chk("R7 top cleared", d, 8'h10);
    wr_reg(0, 8'h64); rd_isr(d); chk("R11 specific", d, 8'h00);
    set_req(8'h00);
    // R10 spurious
    set_req(8'h02); chk("R10 irq", {7'b0, irq}, 8'h01);
    set_req(8'h00); pulse_ack;
    chk("R10 vec", vec, 8'h27);
    rd_isr(d); chk("R10 isr", d, 8'h00);
    // R12 masked line
    wr_reg(1, 8'h01);
    set_req(8'h01); chk("R12 irq", {7'b0, irq}, 8'h00);
    rd_reg(0, d); chk("R12 irr", d, 8'h01);
    wr_reg(1, 8'h00); chk("R12 unmask", {7'b0, irq}, 8'h01);
    set_req(8'h00);
    // R11 rotate on non-specific EOI
    set_req(8'h01); pulse_ack; set_req(8'h00);
    wr_reg(0, 8'hA0); rd_isr(d); chk("R11 rot isr", d, 8'h00);
    set_req(8'h81); pulse_ack; chk("R11 rot vec", vec, 8'h27);
    wr_reg(0, 8'h20); set_req(8'h00);
    // R6 edge mode
    init(0, 8'h40, 0);
    set_req(8'h04); chk("R6 edge irq", {7'b0, irq}, 8'h01);
    pulse_ack; chk("R6 vec", vec, 8'h42);
    rd_reg(0, d); chk("R6 irr held", d, 8'h00);
    wr_reg(0, 8'h20); chk("R6 no retrigger", {7'b0, irq}, 8'h00);
    set_req(8'h00); set_req(8'h04); chk("R6 new edge", {7'b0, irq}, 8'h01);
    pulse_ack; wr_reg(0, 8'h20); set_req(8'h00);
    // R8 auto EOI
    init(1, 8'h08, 1);
    set_req(8'h01); pulse_ack;
    chk("R8 vec", vec, 8'h08);
    rd_isr(d); chk("R8 isr", d, 8'h00);
    chk("R8 irq", {7'b0, irq}, 8'h01);
    set_req(8'h00);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule